// File: doc/BRIEF.md
# Conversion Result Fault Monitor

This block is the digital back end of a ratiometric resistance converter. A conversion timer decides when a measurement finishes; at that moment it raises a request to the converter front end (here a testbench stand-in), takes the 15-bit code offered in the same cycle, compares it against two programmable limits and stores it. Out-of-range comparisons and an input over/under-voltage indication are recorded in sticky status flags. These flags stay set until software issues a qualified clear command.

Software reaches the block through a small byte-wide register port. A transaction is framed by an active-low select line. Conversions run either one at a time, triggered by a command bit and started when the select line rises, or continuously with a fixed period. The period depends on which mains-rejection notch is selected. An active-low ready output falls when a fresh result is stored and rises again when software reads either result byte. While the voltage fault input is active, results are not stored.

Top module: `conv_status_core`

## Requirements
- R1: After reset the configuration reads 00h, both result bytes read 00h, the status byte reads 00h, the upper limit reads FFh/FFh, the lower limit reads 00h/00h, and ready_n is high.
- R2: When a conversion completes without a voltage fault and the code is greater than or equal to bits [15:1] of the upper limit word, status bit 7 becomes 1 and stays 1.
- R3: When a conversion completes without a voltage fault and the code is less than or equal to bits [15:1] of the lower limit word, status bit 6 becomes 1 and stays 1.
- R4: Register index 1 returns code bits [14:7]. Index 2 returns code bits [6:0] in positions [7:1], and bit 0 of index 2 is 1 exactly when any of status bits [7:2] is 1. Index 7 returns the status byte.
- R5: While ov_fault is high, status bit 2 is set every cycle, completed conversions neither change the stored code nor pull ready_n low, and storing resumes once ov_fault is low.
- R6: A write to index 0 with bit 1 = 1 and bits 5, 3 and 2 = 0 clears status bits [7:2]. With any of those three bits set, the clear is ignored. Bit 1 always reads back 0.
- R7: When a clear and a new fault occur in the same cycle, the new fault's bit ends up set; a persisting ov_fault sets bit 2 again right after a clear.
- R8: ready_n goes low on the cycle after a result is stored. It returns high after a read of index 1 or 2; reads of other indices leave it unchanged.
- R9: With configuration bit 6 = 0, writing bit 5 = 1 (bits 3:2 = 0) starts exactly one conversion at the rising edge of sel_n. The request appears T_ONE_60 cycles later (notch bit 0 = 0), and bit 5 reads back 0 afterwards.
- R10: Writing configuration bit 6 = 1 starts continuous conversion. The first request comes after the single-conversion time, and later requests follow every T_RUN_60 or T_RUN_50 cycles, as chosen by bit 0 (1 = 50 Hz). Writing bit 6 = 0 stops the requests.
- R11: Indices 3/4 (upper limit, high/low byte) and 5/6 (lower limit) are writable and read back. Writes to indices 1, 2 and 7 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Active-low transaction select; its rising edge ends a transaction |
| wr_stb | input | 1 | Register write strobe (honoured while sel_n is low) |
| rd_stb | input | 1 | Register read access strobe (honoured while sel_n is low) |
| addr | input | 3 | Register index |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for the selected index |
| adc_req | output | 1 | Conversion complete; the code must be valid in this cycle |
| adc_code | input | 15 | Conversion code from the front end |
| ov_fault | input | 1 | Input over/under-voltage indication |
| ready_n | output | 1 | Active-low result-ready |

## Verification
The bound checker watches the cycle-level rules on every clock. These rules are: a completed in-range conversion must set the matching limit flag; the voltage fault must freeze the stored code and set its flag; a qualified clear with no new cause must empty the flags; a result read must release ready; and ready may only fall after a stored result. The bench's directed scenarios are the only way to show the rest: conversion latency and period for each mode and notch, the one-shot firing on the select edge and only once, byte packing and the summary bit, ignored writes and disqualified clears, and a clear landing in the same cycle as a limit hit.

// File: rtl/conv_pkg.sv
package conv_pkg;
  localparam int RES_W  = 15;
  localparam int WORD_W = RES_W + 1;
  localparam int IDX_W  = 3;

  localparam logic [IDX_W-1:0] IX_CFG   = 3'd0;
  localparam logic [IDX_W-1:0] IX_RES_H = 3'd1;
  localparam logic [IDX_W-1:0] IX_RES_L = 3'd2;
  localparam logic [IDX_W-1:0] IX_UPR_H = 3'd3;
  localparam logic [IDX_W-1:0] IX_UPR_L = 3'd4;
  localparam logic [IDX_W-1:0] IX_LWR_H = 3'd5;
  localparam logic [IDX_W-1:0] IX_LWR_L = 3'd6;
  localparam logic [IDX_W-1:0] IX_STAT  = 3'd7;

  localparam int CB_NOTCH = 0;
  localparam int CB_CLEAR = 1;
  localparam int CB_FD0   = 2;
  localparam int CB_FD1   = 3;
  localparam int CB_WIRE3 = 4;
  localparam int CB_SHOT  = 5;
  localparam int CB_CONT  = 6;
  localparam int CB_BIAS  = 7;

  typedef struct packed {
    logic bias;
    logic cont;
    logic shot;
    logic wire3;
    logic notch50;
  } cfg_t;

  typedef struct packed {
    logic over_hi;
    logic under_lo;
    logic volt;
  } flags_t;
endpackage

// File: rtl/conv_regs.sv
module conv_regs
  import conv_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              wr_stb,
  input  logic [IDX_W-1:0]  addr,
  input  logic [7:0]        wr_data,
  output cfg_t              cfg,
  output logic [WORD_W-1:0] thr_hi,
  output logic [WORD_W-1:0] thr_lo,
  output logic              clr_cmd,
  output logic              start_cmd,
  output logic              stop_cmd,
  output logic              notch_eff
);
  logic              wr_ok, wcfg, sel_q, sel_rise, shot_ok, cont_on, fire;
  logic              thr_en;
  cfg_t              cfg_nx;
  logic [WORD_W-1:0] thi_nx, tlo_nx;

  always_comb begin
    wr_ok    = wr_stb & ~sel_n;
    wcfg     = wr_ok && (addr == IX_CFG);
    sel_rise = sel_n & ~sel_q;
    clr_cmd  = wcfg & wr_data[CB_CLEAR] & ~wr_data[CB_SHOT]
             & ~wr_data[CB_FD1] & ~wr_data[CB_FD0];
    shot_ok  = wcfg & wr_data[CB_SHOT] & ~wr_data[CB_CONT]
             & ~wr_data[CB_FD1] & ~wr_data[CB_FD0];
    cont_on  = wcfg & wr_data[CB_CONT] & ~cfg.cont;
    stop_cmd = wcfg & ~wr_data[CB_CONT] & cfg.cont;
    fire     = sel_rise & cfg.shot & ~cfg.cont;
    start_cmd = cont_on | fire;
    notch_eff = wcfg ? wr_data[CB_NOTCH] : cfg.notch50;

    cfg_nx = cfg;
    if (wcfg) begin
      cfg_nx.bias    = wr_data[CB_BIAS];
      cfg_nx.cont    = wr_data[CB_CONT];
      cfg_nx.wire3   = wr_data[CB_WIRE3];
      cfg_nx.notch50 = wr_data[CB_NOTCH];
      cfg_nx.shot    = shot_ok;
    end else if (sel_rise) begin
      cfg_nx.shot = 1'b0;
    end

    thi_nx = thr_hi;
    tlo_nx = thr_lo;
    thr_en = 1'b0;
    if (wr_ok) begin
      unique case (addr)
        IX_UPR_H: begin thi_nx[15:8] = wr_data; thr_en = 1'b1; end
        IX_UPR_L: begin thi_nx[7:0]  = wr_data; thr_en = 1'b1; end
        IX_LWR_H: begin tlo_nx[15:8] = wr_data; thr_en = 1'b1; end
        IX_LWR_L: begin tlo_nx[7:0]  = wr_data; thr_en = 1'b1; end
        default:  thr_en = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg    <= '0;
      thr_hi <= '1;
      thr_lo <= '0;
      sel_q  <= 1'b1;
    end else begin
      sel_q <= sel_n;
      if (wcfg || sel_rise) cfg <= cfg_nx;
      if (thr_en) begin
        thr_hi <= thi_nx;
        thr_lo <= tlo_nx;
      end
    end
  end
endmodule

// File: rtl/conv_timer.sv
module conv_timer #(
  parameter int T_ONE_60 = 30,
  parameter int T_ONE_50 = 36,
  parameter int T_RUN_60 = 10,
  parameter int T_RUN_50 = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cont,
  input  logic notch50,
  input  logic start,
  input  logic stop,
  output logic done
);
  localparam int M_ONE = (T_ONE_60 > T_ONE_50) ? T_ONE_60 : T_ONE_50;
  localparam int M_RUN = (T_RUN_60 > T_RUN_50) ? T_RUN_60 : T_RUN_50;
  localparam int T_MAX = (M_ONE > M_RUN) ? M_ONE : M_RUN;
  localparam int CW    = $clog2(T_MAX + 1);
  localparam logic [CW-1:0] LD_O60 = CW'(T_ONE_60 - 1);
  localparam logic [CW-1:0] LD_O50 = CW'(T_ONE_50 - 1);
  localparam logic [CW-1:0] LD_R60 = CW'(T_RUN_60 - 1);
  localparam logic [CW-1:0] LD_R50 = CW'(T_RUN_50 - 1);

  logic          busy, busy_nx;
  logic [CW-1:0] cnt, cnt_nx;

  always_comb begin
    done    = busy && (cnt == '0);
    busy_nx = busy;
    cnt_nx  = cnt;
    if (stop) begin
      busy_nx = 1'b0;
    end else if (start) begin
      busy_nx = 1'b1;
      cnt_nx  = notch50 ? LD_O50 : LD_O60;
    end else if (done) begin
      if (cont) cnt_nx = notch50 ? LD_R50 : LD_R60;
      else      busy_nx = 1'b0;
    end else if (busy) begin
      cnt_nx = cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else begin
      busy <= busy_nx;
      if (busy || start) cnt <= cnt_nx;
    end
  end
endmodule

// File: rtl/conv_result.sv
module conv_result
  import conv_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             done,
  input  logic             ov_fault,
  input  logic [RES_W-1:0] code,
  input  logic [RES_W-1:0] lim_hi,
  input  logic [RES_W-1:0] lim_lo,
  input  logic             clr,
  input  logic             rel,
  output logic [RES_W-1:0] res,
  output flags_t           flags,
  output logic             ready_n
);
  logic   take, hit_hi, hit_lo, rdy_nx;
  flags_t flags_nx;

  always_comb begin
    take   = done & ~ov_fault;
    hit_hi = code >= lim_hi;
    hit_lo = code <= lim_lo;

    flags_nx = flags;
    if (clr) flags_nx = '0;
    if (take && hit_hi) flags_nx.over_hi  = 1'b1;
    if (take && hit_lo) flags_nx.under_lo = 1'b1;
    if (ov_fault)       flags_nx.volt     = 1'b1;

    rdy_nx = ready_n;
    if (rel)  rdy_nx = 1'b1;
    if (take) rdy_nx = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res     <= '0;
      flags   <= '0;
      ready_n <= 1'b1;
    end else begin
      if (take) res <= code;
      flags   <= flags_nx;
      ready_n <= rdy_nx;
    end
  end
endmodule

// File: rtl/conv_status_core.sv
module conv_status_core
  import conv_pkg::*;
#(
  parameter int T_ONE_60 = 30,
  parameter int T_ONE_50 = 36,
  parameter int T_RUN_60 = 10,
  parameter int T_RUN_50 = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_n,
  input  logic             wr_stb,
  input  logic             rd_stb,
  input  logic [IDX_W-1:0] addr,
  input  logic [7:0]       wr_data,
  output logic [7:0]       rd_data,
  output logic             adc_req,
  input  logic [RES_W-1:0] adc_code,
  input  logic             ov_fault,
  output logic             ready_n
);
  logic [1:0]        rst_pipe;
  logic              rst_q;
  cfg_t              cfg;
  logic [WORD_W-1:0] thr_hi, thr_lo;
  logic              clr_cmd, start_cmd, stop_cmd, notch_eff, rel;
  logic [RES_W-1:0]  res_q;
  flags_t            flags;
  logic [7:0]        stat_byte;
  logic              fault_any;

  // reset asserts at once, leaves two clocks after rst_n rises
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q = rst_pipe[1];

  conv_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_q),
    .sel_n     (sel_n),
    .wr_stb    (wr_stb),
    .addr      (addr),
    .wr_data   (wr_data),
    .cfg       (cfg),
    .thr_hi    (thr_hi),
    .thr_lo    (thr_lo),
    .clr_cmd   (clr_cmd),
    .start_cmd (start_cmd),
    .stop_cmd  (stop_cmd),
    .notch_eff (notch_eff)
  );

  conv_timer #(
    .T_ONE_60 (T_ONE_60),
    .T_ONE_50 (T_ONE_50),
    .T_RUN_60 (T_RUN_60),
    .T_RUN_50 (T_RUN_50)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_q),
    .cont    (cfg.cont),
    .notch50 (notch_eff),
    .start   (start_cmd),
    .stop    (stop_cmd),
    .done    (adc_req)
  );

  assign rel = rd_stb & ~sel_n & ((addr == IX_RES_H) | (addr == IX_RES_L));

  conv_result u_res (
    .clk      (clk),
    .rst_n    (rst_q),
    .done     (adc_req),
    .ov_fault (ov_fault),
    .code     (adc_code),
    .lim_hi   (thr_hi[WORD_W-1:1]),
    .lim_lo   (thr_lo[WORD_W-1:1]),
    .clr      (clr_cmd),
    .rel      (rel),
    .res      (res_q),
    .flags    (flags),
    .ready_n  (ready_n)
  );

  always_comb begin
    fault_any = |flags;
    stat_byte = {flags.over_hi, flags.under_lo, 3'b000, flags.volt, 2'b00};
    unique case (addr)
      IX_CFG:   rd_data = {cfg.bias, cfg.cont, cfg.shot, cfg.wire3, 3'b000, cfg.notch50};
      IX_RES_H: rd_data = res_q[RES_W-1:7];
      IX_RES_L: rd_data = {res_q[6:0], fault_any};
      IX_UPR_H: rd_data = thr_hi[15:8];
      IX_UPR_L: rd_data = thr_hi[7:0];
      IX_LWR_H: rd_data = thr_lo[15:8];
      IX_LWR_L: rd_data = thr_lo[7:0];
      default:  rd_data = stat_byte;
    endcase
  end
endmodule

// File: rtl/conv_status_core_chk.sv
module conv_status_core_chk
  import conv_pkg::*;
(
  input logic             clk,
  input logic             rst_q,
  input logic             adc_req,
  input logic [RES_W-1:0] adc_code,
  input logic             ov_fault,
  input logic             ready_n,
  input logic             clr_cmd,
  input logic             rel,
  input logic [RES_W-1:0] res_q,
  input flags_t           flags,
  input logic [RES_W-1:0] lim_hi,
  input logic [RES_W-1:0] lim_lo
);
  a_r2_upper_hit: assert property (@(posedge clk) disable iff (!rst_q)
    adc_req && !ov_fault && (adc_code >= lim_hi) |=> flags.over_hi);

  a_r3_lower_hit: assert property (@(posedge clk) disable iff (!rst_q)
    adc_req && !ov_fault && (adc_code <= lim_lo) |=> flags.under_lo);

  a_r5_code_frozen: assert property (@(posedge clk) disable iff (!rst_q)
    ov_fault |=> $stable(res_q));

  a_r7_volt_resets: assert property (@(posedge clk) disable iff (!rst_q)
    ov_fault |=> flags.volt);

  a_r6_clear_empties: assert property (@(posedge clk) disable iff (!rst_q)
    clr_cmd && !ov_fault && !adc_req |=> (flags == '0));

  a_r8_read_releases: assert property (@(posedge clk) disable iff (!rst_q)
    rel && !(adc_req && !ov_fault) |=> ready_n);

  a_r8_fall_cause: assert property (@(posedge clk) disable iff (!rst_q)
    $fell(ready_n) |-> $past(adc_req && !ov_fault));
endmodule

bind conv_status_core conv_status_core_chk u_chk (
  .clk      (clk),
  .rst_q    (rst_q),
  .adc_req  (adc_req),
  .adc_code (adc_code),
  .ov_fault (ov_fault),
  .ready_n  (ready_n),
  .clr_cmd  (clr_cmd),
  .rel      (rel),
  .res_q    (res_q),
  .flags    (flags),
  .lim_hi   (thr_hi[15:1]),
  .lim_lo   (thr_lo[15:1])
);

// File: tb/conv_status_core_tb.sv
module conv_status_core_tb;
  localparam int L60 = 30, L50 = 36, S60 = 10, S50 = 12;

  logic        clk, rst_n, sel_n, wr_stb, rd_stb, ov_fault;
  logic [2:0]  addr;
  logic [7:0]  wr_data, rd_data;
  logic        adc_req, ready_n;
  logic [14:0] adc_code;
  int          n_chk, n_bad;

  conv_status_core #(.T_ONE_60(L60), .T_ONE_50(L50), .T_RUN_60(S60), .T_RUN_50(S50)) u_dut (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .wr_stb(wr_stb), .rd_stb(rd_stb),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .adc_req(adc_req),
    .adc_code(adc_code), .ov_fault(ov_fault), .ready_n(ready_n)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    sel_n = 1'b0; wr_stb = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_stb = 1'b0; sel_n = 1'b1;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    sel_n = 1'b0; rd_stb = 1'b1; addr = a;
    #5 d = rd_data;
    @(negedge clk);
    rd_stb = 1'b0; sel_n = 1'b1;
  endtask

  task automatic wait_req(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!adc_req && n < 1000);
  endtask

  task automatic do_shot(input logic [14:0] code);
    int n;
    adc_code = code;
    wr_reg(3'd0, 8'hA0);
    wait_req(n);
    @(negedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    chk("R1 ready", int'(ready_n), 1);
    rd_reg(3'd0, d); chk("R1 cfg", d, 8'h00);
    rd_reg(3'd1, d); chk("R1 res hi", d, 8'h00);
    rd_reg(3'd2, d); chk("R1 res lo", d, 8'h00);
    rd_reg(3'd3, d); chk("R1 upper hi", d, 8'hFF);
    rd_reg(3'd4, d); chk("R1 upper lo", d, 8'hFF);
    rd_reg(3'd5, d); chk("R1 lower hi", d, 8'h00);
    rd_reg(3'd6, d); chk("R1 lower lo", d, 8'h00);
    rd_reg(3'd7, d); chk("R1 status", d, 8'h00);
  endtask

  task automatic t_limits;
    logic [7:0] d;
    wr_reg(3'd3, 8'h40); wr_reg(3'd4, 8'h00);
    wr_reg(3'd5, 8'h02); wr_reg(3'd6, 8'h00);
    rd_reg(3'd3, d); chk("R11 upper hi", d, 8'h40);
    rd_reg(3'd5, d); chk("R11 lower hi", d, 8'h02);
    wr_reg(3'd1, 8'h55); wr_reg(3'd7, 8'hFF);
    rd_reg(3'd1, d); chk("R11 res write ignored", d, 8'h00);
    rd_reg(3'd7, d); chk("R11 status write ignored", d, 8'h00);
  endtask

  task automatic t_oneshot;
    logic [7:0] d;
    int n, cnt;
    adc_code = 15'h1234;
    wr_reg(3'd0, 8'hA0);
    wait_req(n);
    chk("R9 one-shot latency", n, L60);
    @(negedge clk);
    chk("R8 ready low after store", int'(ready_n), 0);
    rd_reg(3'd0, d); chk("R9 shot bit self-clears", d, 8'h80);
    rd_reg(3'd7, d); chk("R8 other read keeps ready", int'(ready_n), 0);
    rd_reg(3'd1, d); chk("R4 res hi byte", d, 8'h24);
    chk("R8 read releases ready", int'(ready_n), 1);
    rd_reg(3'd2, d); chk("R4 res lo byte", d, 8'h68);
    cnt = 0;
    for (int i = 0; i < 2 * L60; i++) begin
      @(negedge clk);
      if (adc_req) cnt++;
    end
    chk("R9 single conversion only", cnt, 0);
  endtask

  task automatic t_hits;
    logic [7:0] d;
    do_shot(15'h2000);
    rd_reg(3'd7, d); chk("R2 equal to upper", d, 8'h80);
    rd_reg(3'd1, d); chk("R4 hi byte", d, 8'h40);
    rd_reg(3'd2, d); chk("R4 fault summary bit", d, 8'h01);
    wr_reg(3'd0, 8'h82);
    rd_reg(3'd7, d); chk("R6 clear", d, 8'h00);
    do_shot(15'h1FFF);
    rd_reg(3'd7, d); chk("R2 below upper", d, 8'h00);
    rd_reg(3'd2, d); chk("R4 no fault summary", d, 8'hFE);
    do_shot(15'h0101);
    rd_reg(3'd7, d); chk("R3 above lower", d, 8'h00);
    do_shot(15'h0100);
    rd_reg(3'd7, d); chk("R3 equal to lower", d, 8'h40);
  endtask

  task automatic t_clear_rules;
    logic [7:0] d;
    int n;
    adc_code = 15'h1000;
    wr_reg(3'd0, 8'hA2);
    wait_req(n);
    @(negedge clk);
    rd_reg(3'd7, d); chk("R6 clear with shot ignored", d, 8'h40);
    wr_reg(3'd0, 8'h86);
    rd_reg(3'd7, d); chk("R6 clear with bit2 ignored", d, 8'h40);
    rd_reg(3'd0, d); chk("R6 clear bit reads 0", d, 8'h80);
  endtask

  task automatic t_same_cycle;
    logic [7:0] d;
    int n;
    adc_code = 15'h3000;
    wr_reg(3'd0, 8'hA0);
    wait_req(n);
    sel_n = 1'b0; wr_stb = 1'b1; addr = 3'd0; wr_data = 8'h82;
    @(negedge clk);
    wr_stb = 1'b0; sel_n = 1'b1;
    rd_reg(3'd7, d); chk("R7 new fault beats clear", d, 8'h80);
    wr_reg(3'd0, 8'h82);
    rd_reg(3'd1, d);
  endtask

  task automatic t_voltage;
    logic [7:0] d;
    @(negedge clk); ov_fault = 1'b1;
    repeat (2) @(negedge clk);
    rd_reg(3'd7, d); chk("R5 volt flag", d, 8'h04);
    rd_reg(3'd2, d); chk("R5 summary with volt", int'(d[0]), 1);
    do_shot(15'h0555);
    chk("R5 no ready during fault", int'(ready_n), 1);
    rd_reg(3'd1, d); chk("R5 result held", d, 8'h60);
    wr_reg(3'd0, 8'h82);
    rd_reg(3'd7, d); chk("R7 volt re-sets after clear", d, 8'h04);
    @(negedge clk); ov_fault = 1'b0;
    wr_reg(3'd0, 8'h82);
    rd_reg(3'd7, d); chk("R5 clear after fault gone", d, 8'h00);
    do_shot(15'h0555);
    chk("R5 storing resumes", int'(ready_n), 0);
    rd_reg(3'd1, d); chk("R5 new result", d, 8'h0A);
  endtask

  task automatic t_continuous;
    int n, cnt;
    adc_code = 15'h1000;
    wr_reg(3'd0, 8'hC0);
    wait_req(n); chk("R10 first period 60", n, L60 - 1);
    wait_req(n); chk("R10 run period 60", n, S60);
    wait_req(n); chk("R10 run period 60 again", n, S60);
    wr_reg(3'd0, 8'h80);
    cnt = 0;
    for (int i = 0; i < 3 * L60; i++) begin
      @(negedge clk);
      if (adc_req) cnt++;
    end
    chk("R10 stop", cnt, 0);
    wr_reg(3'd0, 8'hC1);
    wait_req(n); chk("R10 first period 50", n, L50 - 1);
    wait_req(n); chk("R10 run period 50", n, S50);
    wr_reg(3'd0, 8'h80);
  endtask

  task automatic report;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
  end

  initial begin
    n_chk = 0; n_bad = 0;
    rst_n = 1'b0; sel_n = 1'b1; wr_stb = 1'b0; rd_stb = 1'b0;
    addr = '0; wr_data = '0; adc_code = '0; ov_fault = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_limits();
    t_oneshot();
    t_hits();
    t_clear_rules();
    t_same_cycle();
    t_voltage();
    t_continuous();
    report();
  end
endmodule